// File: doc/BRIEF.md
# Multiframe Timing Marker Extractor

This block sits behind the receive framer of an E3 line that carries the maintenance-and-adaptation overhead byte. Once per frame it receives the trailing three bits of that byte, which are bits six, seven and eight. A mode input selects one of two ways to treat them.

In integrated mode the three bits form a single field. The field is debounced and held as a 3-bit value. In extracted mode the first two of the bits give the multiframe phase, and the last bit is one bit of a 4-bit timing source word. The block rebuilds that word over a four-frame multiframe, debounces it as a whole, and holds it. It also raises an unstable flag when no word persists.

Each held value has a sticky change flag, which software clears by writing one to it.

Top module: `mf_timing_marker`

## Requirements
- R1: After reset, `int_val` and `ext_val` are zero and `int_chg`, `ext_chg` and `ext_unstable` are low.
- R2: Byte bit eight is `ma_tail[0]`, bit seven is `ma_tail[1]` and bit six is `ma_tail[2]`. In integrated mode the field is `ma_tail[2:0]`, used as is.
- R3: In integrated mode, a field seen on 5 consecutive accepted frames is stored in `int_val` at the clock edge of the fifth frame. Any different field in between restarts the count.
- R4: `int_chg` rises in the cycle in which `int_val` takes a new, different value. It stays high until it is cleared.
- R5: A high `clr_int_chg` or `clr_ext_chg` at an edge clears its flag. If the flag is set by a new value at that same edge, the set wins.
- R6: In extracted mode the phase is `ma_tail[2:1]`. Phase 0 writes `ma_tail[0]` into word bit 3 (the MSB), phase 1 into bit 2, phase 2 into bit 1 and phase 3 into bit 0.
- R7: A multiframe counts only when a phase-3 frame follows frames of phases 0, 1 and 2, all received since the most recent phase-0 frame. A phase-3 frame without all of them yields no word.
- R8: A 4-bit word seen in 5 consecutive complete multiframes is stored in `ext_val` at the phase-3 edge of the fifth multiframe. `ext_chg` rises when that value differs from the one held.
- R9: `ext_unstable` rises after 8 consecutive complete multiframes in which no word reaches 5 repeats. It falls at the first complete multiframe whose word has 5 or more repeats.
- R10: In integrated mode the extracted-path state and outputs are unchanged. In extracted mode the integrated-path state and outputs are unchanged.
- R11: A frame with `byte_valid` low has no effect, and it does not break a run of repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_ext | input | 1 | 0 = integrated 3-bit mode, 1 = extracted 4-bit mode |
| byte_valid | input | 1 | One-cycle strobe: a new overhead byte is on `ma_tail` |
| ma_tail | input | 3 | Bits six, seven and eight of the overhead byte |
| clr_int_chg | input | 1 | Write-one-to-clear strobe for `int_chg` |
| clr_ext_chg | input | 1 | Write-one-to-clear strobe for `ext_chg` |
| int_val | output | 3 | Held field in integrated mode |
| int_chg | output | 1 | Sticky change flag for `int_val` |
| ext_val | output | 4 | Held timing source word |
| ext_chg | output | 1 | Sticky change flag for `ext_val` |
| ext_unstable | output | 1 | No persistent timing source word |

## Verification
The hardest state to reach is `ext_unstable`. It needs eight complete multiframes in a row, with every phase in order, while no word repeats five times. A broken multiframe must not count toward that total.

The stimulus first locks a word. It then sends multiframes whose words alternate between two values, so every multiframe is complete but none is accepted. A later run of one word clears the flag.

A multiframe with a missing phase is placed inside a run of repeats. This shows that the missing phase neither counts nor breaks the run.

// File: rtl/mtm_pkg.sv
package mtm_pkg;

   localparam int MTM_INT_W      = 3;
   localparam int MTM_TSI_W      = 4;
   localparam int MTM_ACCEPT     = 5;
   localparam int MTM_UNST_LIMIT = 8;

   typedef enum logic {
      MODE_INT = 1'b0,
      MODE_EXT = 1'b1
   } mtm_mode_e;

endpackage

// File: rtl/mtm_integ.sv
module mtm_integ #(
   parameter int W      = 3,
   parameter int ACCEPT = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         obs_valid,
   input  logic [W-1:0] obs,
   input  logic         clr,
   output logic [W-1:0] val,
   output logic         chg,
   output logic         held
);

   localparam int             CW   = $clog2(ACCEPT + 1);
   localparam logic [CW-1:0]  CMAX = CW'(ACCEPT);

   if (W < 1) begin : g_bad_w
      $error("mtm_integ: W must be at least 1");
   end
   if (ACCEPT < 2) begin : g_bad_accept
      $error("mtm_integ: ACCEPT must be at least 2");
   end

   logic [W-1:0]  cand;
   logic [CW-1:0] run;
   logic [CW-1:0] run_n;
   logic          same;
   logic          upd;

   // Length of the current run of identical observations, saturating at CMAX
   always_comb begin
      same  = (run != '0) && (obs == cand);
      run_n = same ? ((run == CMAX) ? run : run + 1'b1) : CW'(1);
      held  = obs_valid && (run_n == CMAX);
      upd   = held && (obs != val);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cand <= '0;
         run  <= '0;
         val  <= '0;
         chg  <= 1'b0;
      end else begin
         if (obs_valid) begin
            cand <= obs;
            run  <= run_n;
         end
         if (upd) begin
            val <= obs;
         end
         chg <= upd | (chg & ~clr);
      end
   end

endmodule

// File: rtl/mtm_mf_asm.sv
module mtm_mf_asm #(
   parameter int SLOTS = 4,
   parameter int PW    = $clog2(SLOTS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [PW-1:0]    phase,
   input  logic             mark,
   output logic             word_valid,
   output logic [SLOTS-1:0] word
);

   if (SLOTS < 2 || (1 << PW) != SLOTS) begin : g_bad_slots
      $error("mtm_mf_asm: SLOTS must be a power of two of at least 2");
   end

   logic [SLOTS-1:0] slots;
   logic [SLOTS-1:0] slots_n;
   logic [SLOTS-2:0] seen;
   logic [SLOTS-2:0] seen_n;
   logic             first;
   logic             last;

   assign first = (phase == '0);
   assign last  = (phase == PW'(SLOTS - 1));

   // Phase p fills word bit SLOTS-1-p: the MSB goes first
   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      assign slots_n[i] = (en && phase == PW'(SLOTS - 1 - i)) ? mark : slots[i];
   end

   // Phases seen since the latest phase 0; the final phase closes the multiframe
   for (genvar j = 0; j < SLOTS - 1; j++) begin : g_seen
      assign seen_n[j] = !en  ? seen[j] :
                         first ? ((j == 0) ? 1'b1 : 1'b0) :
                         last  ? 1'b0 :
                                 (seen[j] | (phase == PW'(j)));
   end

   assign word_valid = en && last && (&seen);
   assign word       = slots_n;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slots <= '0;
         seen  <= '0;
      end else begin
         slots <= slots_n;
         seen  <= seen_n;
      end
   end

endmodule

// File: rtl/mtm_unst.sv
module mtm_unst #(
   parameter int LIMIT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic obs_valid,
   input  logic held,
   output logic unstable
);

   localparam int            CW   = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LMAX = CW'(LIMIT);

   if (LIMIT < 1) begin : g_bad_limit
      $error("mtm_unst: LIMIT must be at least 1");
   end

   logic [CW-1:0] miss;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         miss     <= '0;
         unstable <= 1'b0;
      end else if (obs_valid) begin
         if (held) begin
            miss     <= '0;
            unstable <= 1'b0;
         end else begin
            if (miss != LMAX) begin
               miss <= miss + 1'b1;
            end
            if (miss >= LMAX - 1'b1) begin
               unstable <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/mf_timing_marker.sv
module mf_timing_marker
   import mtm_pkg::*;
#(
   parameter int INT_W      = MTM_INT_W,
   parameter int TSI_W      = MTM_TSI_W,
   parameter int ACCEPT     = MTM_ACCEPT,
   parameter int UNST_LIMIT = MTM_UNST_LIMIT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_ext,
   input  logic             byte_valid,
   input  logic [INT_W-1:0] ma_tail,
   input  logic             clr_int_chg,
   input  logic             clr_ext_chg,
   output logic [INT_W-1:0] int_val,
   output logic             int_chg,
   output logic [TSI_W-1:0] ext_val,
   output logic             ext_chg,
   output logic             ext_unstable
);

   localparam int PW = $clog2(TSI_W);

   if (INT_W != PW + 1) begin : g_bad_split
      $error("mf_timing_marker: INT_W must equal phase width plus one");
   end

   mtm_mode_e        mode;
   logic             int_en;
   logic             ext_en;
   logic             int_held;
   logic             ext_held;
   logic             word_valid;
   logic [TSI_W-1:0] word;

   assign mode   = mtm_mode_e'(mode_ext);
   assign int_en = byte_valid && (mode == MODE_INT);
   assign ext_en = byte_valid && (mode == MODE_EXT);

   mtm_integ #(
      .W      (INT_W),
      .ACCEPT (ACCEPT)
   ) i_int_integ (
      .clk       (clk),
      .rst_n     (rst_n),
      .obs_valid (int_en),
      .obs       (ma_tail),
      .clr       (clr_int_chg),
      .val       (int_val),
      .chg       (int_chg),
      .held      (int_held)
   );

   mtm_mf_asm #(
      .SLOTS (TSI_W),
      .PW    (PW)
   ) i_mf_asm (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (ext_en),
      .phase      (ma_tail[INT_W-1:1]),
      .mark       (ma_tail[0]),
      .word_valid (word_valid),
      .word       (word)
   );

   mtm_integ #(
      .W      (TSI_W),
      .ACCEPT (ACCEPT)
   ) i_ext_integ (
      .clk       (clk),
      .rst_n     (rst_n),
      .obs_valid (word_valid),
      .obs       (word),
      .clr       (clr_ext_chg),
      .val       (ext_val),
      .chg       (ext_chg),
      .held      (ext_held)
   );

   mtm_unst #(
      .LIMIT (UNST_LIMIT)
   ) i_unst (
      .clk       (clk),
      .rst_n     (rst_n),
      .obs_valid (word_valid),
      .held      (ext_held),
      .unstable  (ext_unstable)
   );

endmodule

// File: rtl/mtm_chk.sv
module mtm_chk #(
   parameter int INT_W = 3,
   parameter int TSI_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mode_ext,
   input logic             byte_valid,
   input logic [INT_W-1:0] ma_tail,
   input logic             clr_int_chg,
   input logic             clr_ext_chg,
   input logic [INT_W-1:0] int_val,
   input logic             int_chg,
   input logic [TSI_W-1:0] ext_val,
   input logic             ext_chg,
   input logic             ext_unstable,
   input logic             int_held
);

   AST_INT_HELD_STORES: assert property (@(posedge clk) disable iff (!rst_n)
      int_held |=> (int_val == $past(ma_tail)));                             // R3

   AST_INT_NEW_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(int_val) |-> int_chg);                                        // R4

   AST_INT_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (int_chg && !clr_int_chg) |=> int_chg);                                // R4

   AST_INT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr_int_chg |=> (!int_chg || !$stable(int_val)));                      // R5

   AST_EXT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr_ext_chg |=> (!ext_chg || !$stable(ext_val)));                      // R5

   AST_EXT_NEW_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ext_val) |-> ext_chg);                                        // R8

   AST_UNST_ONLY_EXT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ext_unstable) |-> $past(mode_ext && byte_valid));                // R9

   AST_INT_MODE_KEEPS_EXT: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_ext |=> ($stable(ext_val) && $stable(ext_unstable)));            // R10

   AST_EXT_MODE_KEEPS_INT: assert property (@(posedge clk) disable iff (!rst_n)
      mode_ext |=> $stable(int_val));                                        // R10

   AST_IDLE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_valid |=> ($stable(int_val) && $stable(ext_val) && $stable(ext_unstable))); // R11

endmodule

bind mf_timing_marker mtm_chk #(
   .INT_W (INT_W),
   .TSI_W (TSI_W)
) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mode_ext     (mode_ext),
   .byte_valid   (byte_valid),
   .ma_tail      (ma_tail),
   .clr_int_chg  (clr_int_chg),
   .clr_ext_chg  (clr_ext_chg),
   .int_val      (int_val),
   .int_chg      (int_chg),
   .ext_val      (ext_val),
   .ext_chg      (ext_chg),
   .ext_unstable (ext_unstable),
   .int_held     (int_held)
);

// File: tb/test_mf_timing_marker.sv
module test_mf_timing_marker;

   localparam time CLK_PERIOD = 10ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_ext = 1'b0;
   logic       byte_valid = 1'b0;
   logic [2:0] ma_tail = '0;
   logic       clr_int_chg = 1'b0;
   logic       clr_ext_chg = 1'b0;
   logic [2:0] int_val;
   logic       int_chg;
   logic [3:0] ext_val;
   logic       ext_chg;
   logic       ext_unstable;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   mf_timing_marker i_mf_timing_marker (
      .clk          (clk),
      .rst_n        (rst_n),
      .mode_ext     (mode_ext),
      .byte_valid   (byte_valid),
      .ma_tail      (ma_tail),
      .clr_int_chg  (clr_int_chg),
      .clr_ext_chg  (clr_ext_chg),
      .int_val      (int_val),
      .int_chg      (int_chg),
      .ext_val      (ext_val),
      .ext_chg      (ext_chg),
      .ext_unstable (ext_unstable)
   );

   typedef struct {
      string      tag;
      logic [2:0] iv;
      logic       ic;
      logic [3:0] ev;
      logic       ec;
      logic       un;
   } exp_t;

   exp_t q[$];

   // Reference model, written from the requirements
   logic [2:0] m_icand = '0, m_iv = '0;
   int         m_ir = 0;
   logic       m_ic = 1'b0;
   logic [3:0] m_slot = '0, m_ecand = '0, m_ev = '0;
   logic [2:0] m_seen = '0;
   int         m_er = 0, m_uc = 0;
   logic       m_ec = 1'b0, m_un = 1'b0;

   task automatic model(input bit m, input bit v, input logic [2:0] f,
                        input bit ci, input bit ce);
      bit iupd = 0;
      bit eupd = 0;
      bit closed;
      int ph;
      if (v && !m) begin
         if (m_ir > 0 && f == m_icand) begin
            if (m_ir < 5) m_ir++;
         end else begin
            m_icand = f;
            m_ir    = 1;
         end
         if (m_ir == 5 && f != m_iv) begin
            m_iv = f;
            iupd = 1;
         end
      end
      m_ic = iupd || (m_ic && !ci);
      if (v && m) begin
         ph = int'(f[2:1]);
         m_slot[3 - ph] = f[0];
         closed = (ph == 3) && (m_seen == 3'b111);
         if (ph == 0)      m_seen = 3'b001;
         else if (ph == 3) m_seen = 3'b000;
         else              m_seen[ph] = 1'b1;
         if (closed) begin
            if (m_er > 0 && m_slot == m_ecand) begin
               if (m_er < 5) m_er++;
            end else begin
               m_ecand = m_slot;
               m_er    = 1;
            end
            if (m_er == 5) begin
               m_uc = 0;
               m_un = 1'b0;
               if (m_slot != m_ev) begin
                  m_ev = m_slot;
                  eupd = 1;
               end
            end else begin
               if (m_uc < 8) m_uc++;
               if (m_uc == 8) m_un = 1'b1;
            end
         end
      end
      m_ec = eupd || (m_ec && !ce);
   endtask

   // Driver: apply one cycle of stimulus, then queue the expected outputs
   task automatic send(input bit m, input bit v, input logic [2:0] f,
                       input bit ci, input bit ce, input string tag);
      exp_t e;
      @(negedge clk);
      mode_ext    = m;
      byte_valid  = v;
      ma_tail     = f;
      clr_int_chg = ci;
      clr_ext_chg = ce;
      @(posedge clk);
      #1;
      model(m, v, f, ci, ce);
      e.tag = tag; e.iv = m_iv; e.ic = m_ic; e.ev = m_ev; e.ec = m_ec; e.un = m_un;
      q.push_back(e);
   endtask

   task automatic mf(input logic [3:0] w, input string tag);
      for (int p = 0; p < 4; p++) begin
         send(1'b1, 1'b1, {2'(p), w[3 - p]}, 1'b0, 1'b0, tag);
      end
   endtask

   // Monitor: compare the outputs against the queued expectations
   initial begin
      forever begin
         @(negedge clk);
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (int_val !== e.iv || int_chg !== e.ic || ext_val !== e.ev ||
                ext_chg !== e.ec || ext_unstable !== e.un) begin
               errors++;
               $display("FAIL %s: got iv=%0h ic=%0b ev=%0h ec=%0b un=%0b exp iv=%0h ic=%0b ev=%0h ec=%0b un=%0b",
                        e.tag, int_val, int_chg, ext_val, ext_chg, ext_unstable,
                        e.iv, e.ic, e.ev, e.ec, e.un);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got running exp finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      checks++;
      if (int_val !== 3'd0 || int_chg !== 1'b0 || ext_val !== 4'd0 ||
          ext_chg !== 1'b0 || ext_unstable !== 1'b0) begin
         errors++;
         $display("FAIL R1: got iv=%0h ic=%0b ev=%0h ec=%0b un=%0b exp all zero",
                  int_val, int_chg, ext_val, ext_chg, ext_unstable);
      end
      rst_n = 1'b1;

      // R2 R3 R4: field 5 held on its fifth frame
      for (int k = 0; k < 5; k++) send(1'b0, 1'b1, 3'd5, 1'b0, 1'b0, "R3_first_run");
      // R5: plain clear
      send(1'b0, 1'b0, 3'd0, 1'b1, 1'b0, "R5_clear");
      // R3: broken run does not store
      for (int k = 0; k < 3; k++) send(1'b0, 1'b1, 3'd2, 1'b0, 1'b0, "R3_broken");
      send(1'b0, 1'b1, 3'd6, 1'b0, 1'b0, "R3_breaker");
      for (int k = 0; k < 4; k++) send(1'b0, 1'b1, 3'd2, 1'b0, 1'b0, "R3_restart");
      send(1'b0, 1'b1, 3'd2, 1'b0, 1'b0, "R3_fifth");
      // R11: idle frames with another field neither count nor break the run
      for (int k = 0; k < 4; k++) send(1'b0, 1'b1, 3'd1, 1'b1, 1'b0, "R11_run");
      send(1'b0, 1'b0, 3'd7, 1'b0, 1'b0, "R11_idle");
      send(1'b0, 1'b1, 3'd1, 1'b0, 1'b0, "R11_resume");
      // R5: set wins over a simultaneous clear
      for (int k = 0; k < 4; k++) send(1'b0, 1'b1, 3'd3, 1'b1, 1'b0, "R5_prep");
      send(1'b0, 1'b1, 3'd3, 1'b1, 1'b0, "R5_set_wins");
      send(1'b0, 1'b1, 3'd3, 1'b1, 1'b0, "R5_then_clear");

      // R6 R8 R10: extracted word A locks after five multiframes
      for (int k = 0; k < 5; k++) mf(4'hA, "R8_lock_A");
      mf(4'hA, "R10_int_kept");
      send(1'b1, 1'b0, 3'd0, 1'b0, 1'b1, "R5_ext_clear");
      // R7: an incomplete multiframe neither counts nor breaks the run
      for (int k = 0; k < 4; k++) mf(4'h6, "R7_run");
      send(1'b1, 1'b1, 3'b000, 1'b0, 1'b0, "R7_ph0");
      send(1'b1, 1'b1, 3'b011, 1'b0, 1'b0, "R7_ph1");
      send(1'b1, 1'b1, 3'b111, 1'b0, 1'b0, "R7_ph3_no_ph2");
      mf(4'h6, "R7_fifth");
      // R9: eight complete multiframes with no accepted word
      for (int k = 0; k < 4; k++) begin
         mf(4'h3, "R9_alt");
         mf(4'hC, "R9_alt");
      end
      for (int k = 0; k < 5; k++) mf(4'h5, "R9_recover");
      // R10: integrated mode leaves extracted state alone
      for (int k = 0; k < 5; k++) send(1'b0, 1'b1, 3'd4, 1'b0, 1'b1, "R10_ext_kept");

      send(1'b0, 1'b0, 3'd0, 1'b0, 1'b0, "R11_tail");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule